// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit up-counting timer behind a small register bus. The counter advances once per prescaler terminal count. The divisor comes from the upper byte of the control word plus one, and the divide-by-16 source multiplies it by 16. When the count equals the programmed reference on a tick, a reference flag is raised. With restart enabled, the count returns to zero. The flag drives an interrupt line when the interrupt-enable bit is set. Software clears the flag by writing ones to the flag register.

Registers are reached by a single-cycle write strobe and a combinational read port. Writing the control word or the reference restarts both the prescaler and the counter with the new settings. Writing the counter register loads the count directly. The capture-edge and output-mode fields are stored and read back, and they do nothing else.

Top module: `refcmp_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Control (offset 0x0), reference (0x4) and capture (0x8) read back the last value written, including bits 7:5 of the control word. The count reads at 0xC. The flags read at 0x11 in bits 1:0, with bit 1 the reference flag and bit 0 the capture flag.
- R3: With control bit 0 = 1 and bits 2:1 = 1, the count rises by one every (bits 15:8 + 1) clocks.
- R4: With bits 2:1 = 2, the divisor is 16 × (bits 15:8 + 1).
- R5: The count holds its value while bit 0 = 0, or while bits 2:1 are 0 or 3.
- R6: With bit 3 = 1, a tick taken while the count equals the reference sets the reference flag and returns the count to 0.
- R7: `irq` is high exactly when control bit 4 and the reference flag are both 1.
- R8: A write to 0x11 clears each flag whose data bit is 1 and leaves the others unchanged.
- R9: With bit 3 = 0, the count keeps running past the reference and still sets the flag. It wraps from 0xFFFF to 0x0000.
- R10: Reads of unmapped offsets return 0, and writes to them change no register.
- R11: A write to 0xC loads the count on that edge and takes precedence over a tick in the same cycle.
- R12: A control write that takes bit 0 from 1 to 0 also zeroes the reference. If bit 0 was already 0, the reference is kept.
- R13: A write to the control word or to the reference restarts the prescaler and the count from 0.
- R14: When a reference match and a flag-clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Reference interrupt |

## Verification
Two events can land on the same edge: a hardware reference match that sets the flag, and a software write that clears it. The bench runs the counter with a short reference and times a clear so that its write edge coincides with a known match edge. The flag must read set afterwards, and a second clear one cycle later must remove it. In the same way, a counter load is issued while ticks arrive every clock. The loaded value must appear unchanged after that edge and then continue counting from there.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;
    localparam int DATA_W      = 16;
    localparam int PSC_FIELD_W = 8;
    localparam int DIV16_SHIFT = 4;
    localparam int PSC_W       = PSC_FIELD_W + DIV16_SHIFT;
    localparam int FLAG_W      = 2;
    localparam int FLAG_CAP    = 0;
    localparam int FLAG_REF    = 1;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_REF   = 8'h04;
    localparam logic [7:0] OFS_CAPT  = 8'h08;
    localparam logic [7:0] OFS_COUNT = 8'h0C;
    localparam logic [7:0] OFS_FLAGS = 8'h11;

    typedef enum logic [1:0] {
        SRC_HALT_LO = 2'd0,
        SRC_SYSCLK  = 2'd1,
        SRC_DIV16   = 2'd2,
        SRC_HALT_HI = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic [PSC_FIELD_W-1:0] presc;
        logic [1:0]             cap_edge;
        logic                   out_toggle;
        logic                   ref_irq_en;
        logic                   restart;
        clk_src_e               src;
        logic                   enable;
    } mode_t;

    function automatic logic counting(mode_t m);
        return m.enable && (m.src == SRC_SYSCLK || m.src == SRC_DIV16);
    endfunction

    function automatic logic [PSC_W-1:0] last_phase(mode_t m);
        if (m.src == SRC_DIV16)
            return {m.presc, {DIV16_SHIFT{1'b1}}};
        return {{DIV16_SHIFT{1'b0}}, m.presc};
    endfunction
endpackage

// File: rtl/refcmp_prescaler.sv
module refcmp_prescaler
    import refcmp_pkg::*;
#(
    parameter int W = PSC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] last,
    output logic         tick
);
    logic [W-1:0] phase;

    assign tick = run && (phase == last);

    always_ff @(posedge clk) begin
        if (rst || clear || !run)
            phase <= '0;
        else if (tick)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
        run && !clear && !$past(clear) |-> phase <= last);
endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic [W-1:0] ref_val,
    input  logic         restart_en,
    output logic [W-1:0] count,
    output logic         ref_hit
);
    assign ref_hit = tick && (count == ref_val);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (clear)
            count <= '0;
        else if (tick)
            count <= (ref_hit && restart_en) ? '0 : count + 1'b1;
    end

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));
    assert_restart_zero_R13: assert property (@(posedge clk) disable iff (rst)
        clear && !load |=> count == '0);
    assert_step_R9: assert property (@(posedge clk) disable iff (rst)
        tick && !ref_hit && !load && !clear |=> count == $past(count) + 1'b1);
    assert_match_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        ref_hit && restart_en && !load && !clear |=> count == '0);
endmodule

// File: rtl/refcmp_regs.sv
module refcmp_regs
    import refcmp_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count_val,
    input  logic              ref_hit,
    output mode_t             mode,
    output logic [DATA_W-1:0] ref_val,
    output logic [FLAG_W-1:0] flags,
    output logic              recal,
    output logic              load,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [DATA_W-1:0] capt_q;
    logic sel_mode, sel_ref, sel_capt, sel_count, sel_flags;
    logic [FLAG_W-1:0] clr_mask, set_mask;

    assign sel_mode  = (bus_addr == ADDR_W'(OFS_MODE));
    assign sel_ref   = (bus_addr == ADDR_W'(OFS_REF));
    assign sel_capt  = (bus_addr == ADDR_W'(OFS_CAPT));
    assign sel_count = (bus_addr == ADDR_W'(OFS_COUNT));
    assign sel_flags = (bus_addr == ADDR_W'(OFS_FLAGS));

    assign recal    = bus_wr && (sel_mode || sel_ref);
    assign load     = bus_wr && sel_count;
    assign clr_mask = (bus_wr && sel_flags) ? bus_wdata[FLAG_W-1:0] : '0;

    always_comb begin
        set_mask = '0;
        set_mask[FLAG_REF] = ref_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= '0;
            ref_val <= '0;
            capt_q  <= '0;
            flags   <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | set_mask;
            if (bus_wr && sel_mode) begin
                mode <= mode_t'(bus_wdata);
                if (mode.enable && !bus_wdata[0])
                    ref_val <= '0;
            end
            if (bus_wr && sel_ref)
                ref_val <= bus_wdata;
            if (bus_wr && sel_capt)
                capt_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_mode)  bus_rdata = mode;
        if (sel_ref)   bus_rdata = ref_val;
        if (sel_capt)  bus_rdata = capt_q;
        if (sel_count) bus_rdata = count_val;
        if (sel_flags) bus_rdata = DATA_W'(flags);
    end

    assert_set_wins_R14: assert property (@(posedge clk) disable iff (rst)
        ref_hit |=> flags[FLAG_REF]);
    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        bus_wr && sel_flags && bus_wdata[FLAG_REF] && !ref_hit |=> !flags[FLAG_REF]);
    assert_disable_clears_ref_R12: assert property (@(posedge clk) disable iff (rst)
        bus_wr && sel_mode && mode.enable && !bus_wdata[0] |=> ref_val == '0);
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
    import refcmp_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    mode_t             mode;
    logic [DATA_W-1:0] ref_val, count;
    logic [FLAG_W-1:0] flags;
    logic              recal, load, tick, ref_hit, run;

    assign run = counting(mode);
    assign irq = mode.ref_irq_en && flags[FLAG_REF];

    refcmp_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .count_val(count), .ref_hit(ref_hit),
        .mode(mode), .ref_val(ref_val), .flags(flags), .recal(recal),
        .load(load), .bus_rdata(bus_rdata)
    );

    refcmp_prescaler #(.W(PSC_W)) u_psc (
        .clk(clk), .rst(rst), .clear(recal), .run(run),
        .last(last_phase(mode)), .tick(tick)
    );

    refcmp_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst(rst), .clear(recal), .load(load),
        .load_val(bus_wdata), .tick(tick), .ref_val(ref_val),
        .restart_en(mode.restart), .count(count), .ref_hit(ref_hit)
    );

    assert_halt_R5: assert property (@(posedge clk) disable iff (rst)
        !run && !load && !recal |=> count == $past(count));
endmodule

// File: tb/refcmp_timer_tb.sv
module refcmp_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    refcmp_timer #(.ADDR_W(5)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [4:0] a, logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        rd_chk("R1 mode", 5'h00, 16'h0);
        rd_chk("R1 ref", 5'h04, 16'h0);
        rd_chk("R1 capt", 5'h08, 16'h0);
        rd_chk("R1 count", 5'h0C, 16'h0);
        rd_chk("R1 flags", 5'h11, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic test_regs();
        wr(5'h00, 16'h00E0);
        rd_chk("R2 mode readback", 5'h00, 16'h00E0);
        wr(5'h08, 16'hBEEF);
        rd_chk("R2 capt readback", 5'h08, 16'hBEEF);
        wr(5'h04, 16'h0077);
        rd_chk("R2 ref readback", 5'h04, 16'h0077);
        wr(5'h02, 16'hFFFF);
        wr(5'h14, 16'hFFFF);
        rd_chk("R10 unmapped read", 5'h02, 16'h0);
        rd_chk("R10 mode kept", 5'h00, 16'h00E0);
        rd_chk("R10 capt kept", 5'h08, 16'hBEEF);
        rd_chk("R10 ref kept", 5'h04, 16'h0077);
        rd_chk("R10 flags kept", 5'h11, 16'h0);
        rd_chk("R2 count idle", 5'h0C, 16'h0);
        check("R2 irq idle", {15'h0, irq}, 16'h0);
    endtask

    task automatic test_prescale();
        wr(5'h04, 16'h1000);
        wr(5'h00, 16'h000B);
        waitn(10);
        rd_chk("R3 div1 count", 5'h0C, 16'd10);
        wr(5'h00, 16'h030B);
        waitn(20);
        rd_chk("R3 div4 count", 5'h0C, 16'd5);
    endtask

    task automatic test_div16();
        wr(5'h00, 16'h010D);
        waitn(95);
        rd_chk("R4 div32 before edge", 5'h0C, 16'd2);
        waitn(1);
        rd_chk("R4 div32 at edge", 5'h0C, 16'd3);
    endtask

    task automatic test_halt();
        wr(5'h00, 16'h000A);
        wr(5'h0C, 16'h0007);
        waitn(10);
        rd_chk("R5 enable off holds", 5'h0C, 16'd7);
        wr(5'h00, 16'h0009);
        waitn(10);
        rd_chk("R5 source 0 holds", 5'h0C, 16'd0);
        wr(5'h00, 16'h000F);
        waitn(10);
        rd_chk("R5 source 3 holds", 5'h0C, 16'd0);
        wr(5'h00, 16'h0000);
    endtask

    task automatic test_match();
        wr(5'h04, 16'h0004);
        wr(5'h00, 16'h001B);
        waitn(4);
        rd_chk("R6 count at ref", 5'h0C, 16'd4);
        rd_chk("R6 no flag yet", 5'h11, 16'h0);
        check("R7 irq low", {15'h0, irq}, 16'h0);
        waitn(1);
        rd_chk("R6 restarted", 5'h0C, 16'd0);
        rd_chk("R6 flag set", 5'h11, 16'h2);
        check("R7 irq high", {15'h0, irq}, 16'h1);
        wr(5'h00, 16'h000A);
        check("R7 irq masked", {15'h0, irq}, 16'h0);
        rd_chk("R7 flag kept", 5'h11, 16'h2);
    endtask

    task automatic test_w1c();
        wr(5'h11, 16'h0001);
        rd_chk("R8 other bit kept", 5'h11, 16'h2);
        wr(5'h11, 16'h0002);
        rd_chk("R8 ref bit cleared", 5'h11, 16'h0);
    endtask

    task automatic test_freerun();
        wr(5'h04, 16'h0002);
        wr(5'h00, 16'h0003);
        waitn(2);
        rd_chk("R9 at ref", 5'h0C, 16'd2);
        waitn(1);
        rd_chk("R9 past ref", 5'h0C, 16'd3);
        rd_chk("R9 flag set", 5'h11, 16'h2);
        wr(5'h0C, 16'hFFFE);
        rd_chk("R11 load beats tick", 5'h0C, 16'hFFFE);
        waitn(1);
        rd_chk("R9 top", 5'h0C, 16'hFFFF);
        waitn(1);
        rd_chk("R9 wrap", 5'h0C, 16'h0000);
        wr(5'h00, 16'h0002);
        wr(5'h11, 16'h0003);
    endtask

    task automatic test_disable_clear();
        wr(5'h04, 16'h1234);
        wr(5'h00, 16'h0001);
        wr(5'h00, 16'h0000);
        rd_chk("R12 ref cleared", 5'h04, 16'h0);
        wr(5'h04, 16'h0055);
        wr(5'h00, 16'h0010);
        rd_chk("R12 ref kept", 5'h04, 16'h0055);
    endtask

    task automatic test_recal();
        wr(5'h04, 16'h0100);
        wr(5'h00, 16'h000B);
        waitn(7);
        rd_chk("R13 running", 5'h0C, 16'd7);
        wr(5'h04, 16'h0200);
        rd_chk("R13 ref write restarts", 5'h0C, 16'd0);
        waitn(3);
        rd_chk("R13 resumes", 5'h0C, 16'd3);
        wr(5'h00, 16'h000B);
        rd_chk("R13 mode write restarts", 5'h0C, 16'd0);
        wr(5'h00, 16'h0000);
    endtask

    task automatic test_collide();
        wr(5'h04, 16'h0003);
        wr(5'h00, 16'h000B);
        waitn(7);
        wr(5'h11, 16'h0002);
        rd_chk("R14 set beats clear", 5'h11, 16'h2);
        wr(5'h11, 16'h0002);
        rd_chk("R14 later clear works", 5'h11, 16'h0);
        wr(5'h00, 16'h0000);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        waitn(3);
        rst = 1'b0;
        test_reset();
        test_regs();
        test_prescale();
        test_div16();
        test_halt();
        test_match();
        test_w1c();
        test_freerun();
        test_disable_clear();
        test_recal();
        test_collide();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule